// File: doc/BRIEF.md
# I2C Target Interface Controller

This block lets a chip answer as a target on a two-wire I2C bus. A host on the bus addresses it with a 7-bit address. It can then write bytes into the chip or read bytes out of it. Software sees a small register set on a 32-bit word bus: a control register, a status register, an interrupt-enable register, the own-address register and one data port that is shared by both directions.

The bus lines come in as plain inputs. The block pulls SDA low through an output-enable pin; the pad drives zero whenever that pin is high. SCL is only observed, and the block never stretches the clock. For that reason, software must stay one byte ahead when the host reads.

Each bus event sets its own status bit:

- an address match,
- a received byte,
- a request for the next byte to send,
- the end of a sent byte,
- a STOP,
- a general-call match.

Software clears each bit on its own. The interrupt line goes high when any status bit and its enable bit are both set.

Top module: `i2c_tgt_ctrl`

## Requirements
- R1: After reset, control, status, interrupt-enable and own-address all read 0, `irq` is low and `sda_oe` is low.
- R2: When control bit 2 (interface enable) is set, an address byte whose upper seven bits equal the own-address register is acknowledged by pulling SDA low in the ninth clock slot, and status bit 0 is set. A byte with another address, or any address while bit 2 is clear, gets no acknowledge and sets no status bit.
- R3: Address 0 is acknowledged only when control bit 1 is set. Its acknowledge sets status bit 6 together with status bit 0.
- R4: After a match with the direction bit at 0, the data port reads back the address byte itself (a dummy value). After each further byte, the data port holds that byte, status bit 1 is set and the byte is acknowledged.
- R5: While control bit 0 is set, the acknowledge slot after a received data byte is left released (NACK). The block then ignores the bus until the next START.
- R6: After a match with the direction bit at 1:
  - status bit 5 is set;
  - the byte last written to the data port (offset 0x24) is sent MSB first;
  - status bit 3 is set each time a byte is taken for sending;
  - status bit 2 is set at the end of each sent byte's acknowledge slot;
  - a NACK from the host ends sending, with SDA released and bit 3 not set again.
- R7: A STOP seen after this target was addressed sets status bit 4. A STOP on a transfer to another address sets nothing.
- R8: A write to status clears the bits written as 0 and leaves the bits written as 1 unchanged. A write never sets a bit.
- R9: `irq` is high exactly when the AND of status and interrupt-enable is nonzero.
- R10: Register offsets: 0x00 control (4 bits), 0x08 status (7 bits), 0x10 interrupt enable (7 bits), 0x1C own address (7 bits, unshifted), 0x24 data port. Reads are zero-extended to 32 bits, and an unmapped offset reads 0.
- R11: The block changes the SDA level it drives only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; bus lines are sampled on it |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe for one cycle |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt request |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | High pulls SDA low |

## Verification
The bench runs a behavioural host through these corner cases:
- **Wrong address.** A design that decoded the address loosely would acknowledge it, and would flag a STOP on a transfer it never took part in.
- **Disabled interface.** A design that ignored the enable bit would answer while switched off.
- **General call with and without its enable.** A design that got this wrong would claim every address-0 transfer.
- **Forced NACK.** A design that sampled the force bit too late would still acknowledge that byte.
- **Read ended by a host NACK.** A design that reloaded regardless would keep driving SDA and block the STOP, and would raise the data-empty flag once too often.
- **Status write with ones.** A design that OR-ed the write data into status would set flags that no event raised.
- **Ordering of the read transfer.** The bench writes each byte one slot ahead. A shifter loaded at the wrong edge would send the previous byte or a stale one.

// File: rtl/i2c_tgt_pkg.sv
// Shared constants and types for the I2C target controller.
// Assumes: 8-bit bus bytes, 7-bit addressing only.
package i2c_tgt_pkg;
    localparam int BYTE_W = 8;
    localparam int ST_W   = 7;
    localparam int CT_W   = 4;
    localparam int ADR_W  = 7;

    // register byte offsets
    localparam int OFS_CTRL = 'h00;
    localparam int OFS_STAT = 'h08;
    localparam int OFS_IEN  = 'h10;
    localparam int OFS_OWN  = 'h1C;
    localparam int OFS_DATA = 'h24;

    // control bit positions
    localparam int CB_FNACK = 0;
    localparam int CB_GCEN  = 1;
    localparam int CB_EN    = 2;

    // status / interrupt-enable bit positions
    localparam int SB_ADR   = 0;
    localparam int SB_RX    = 1;
    localparam int SB_TXD   = 2;
    localparam int SB_EMPTY = 3;
    localparam int SB_STOP  = 4;
    localparam int SB_TXM   = 5;
    localparam int SB_GC    = 6;

    typedef enum logic [2:0] {
        LK_IDLE, LK_ADDR, LK_AACK, LK_RX, LK_RACK, LK_TX, LK_TACK
    } lk_state_t;
endpackage

// File: rtl/i2c_tgt_sync.sv
// Brings SCL and SDA into the clock domain and flags edges and bus conditions.
// Assumes: the system clock runs several times faster than SCL.
module i2c_tgt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_q, sda_q, scl_s;

    // Synchronizer chains plus one history flop; idle bus reads high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    // Edge and START/STOP decode from synchronized levels.
    always_comb begin
        scl_s     = scl_pipe[STAGES-1];
        sda_s     = sda_pipe[STAGES-1];
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/i2c_tgt_link.sv
// Bit-level target engine: address compare, receive, transmit and acknowledge.
// Assumes: SDA events arrive already synchronized; no clock stretching.
module i2c_tgt_link
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              en,
    input  logic              gc_en,
    input  logic              force_nack,
    input  logic [ADR_W-1:0]  own_addr,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] rx_byte,
    output logic [ST_W-1:0]   ev
);
    localparam int CW = $clog2(BYTE_W + 1);

    lk_state_t         state;
    logic [CW-1:0]     cnt;
    logic [BYTE_W-1:0] sh, tsh;
    logic              rw_q, sel, host_ack, nak_q;
    logic              gc_hit, hit, byte_done, quiet_fall;

    // Address decode on the byte being shifted in.
    always_comb begin
        gc_hit     = gc_en && (sh[BYTE_W-1:1] == '0);
        hit        = en && ((sh[BYTE_W-1:1] == own_addr) || gc_hit);
        quiet_fall = scl_fall && !start_det && !stop_det;
        byte_done  = quiet_fall && (cnt == CW'(BYTE_W));
    end

    // Protocol state machine and SDA drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= LK_IDLE;
            cnt      <= '0;
            sh       <= '0;
            tsh      <= '0;
            sda_oe   <= 1'b0;
            rx_byte  <= '0;
            rw_q     <= 1'b0;
            sel      <= 1'b0;
            host_ack <= 1'b0;
            nak_q    <= 1'b0;
        end else if (start_det) begin
            state  <= LK_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
            sel    <= 1'b0;
        end else if (stop_det) begin
            state  <= LK_IDLE;
            sda_oe <= 1'b0;
            sel    <= 1'b0;
        end else begin
            case (state)
                LK_ADDR, LK_RX: begin
                    if (scl_rise) begin
                        sh  <= {sh[BYTE_W-2:0], sda_s};
                        cnt <= cnt + 1'b1;
                    end else if (byte_done) begin
                        cnt <= '0;
                        if (state == LK_ADDR) begin
                            if (hit) begin
                                state   <= LK_AACK;
                                sda_oe  <= 1'b1;
                                sel     <= 1'b1;
                                rw_q    <= sh[0];
                                rx_byte <= sh;
                            end else begin
                                state <= LK_IDLE;
                            end
                        end else begin
                            rx_byte <= sh;
                            state   <= LK_RACK;
                            sda_oe  <= !force_nack;
                            nak_q   <= force_nack;
                        end
                    end
                end
                LK_AACK: if (scl_fall) begin
                    if (rw_q) begin
                        state  <= LK_TX;
                        tsh    <= tx_byte;
                        sda_oe <= !tx_byte[BYTE_W-1];
                    end else begin
                        state  <= LK_RX;
                        sda_oe <= 1'b0;
                    end
                end
                LK_RACK: if (scl_fall) begin
                    sda_oe <= 1'b0;
                    state  <= nak_q ? LK_IDLE : LK_RX;
                end
                LK_TX: if (scl_fall) begin
                    if (cnt == CW'(BYTE_W - 1)) begin
                        sda_oe <= 1'b0;
                        cnt    <= '0;
                        state  <= LK_TACK;
                    end else begin
                        cnt    <= cnt + 1'b1;
                        tsh    <= {tsh[BYTE_W-2:0], 1'b0};
                        sda_oe <= !tsh[BYTE_W-2];
                    end
                end
                LK_TACK: begin
                    if (scl_rise) begin
                        host_ack <= !sda_s;
                    end else if (scl_fall) begin
                        if (host_ack) begin
                            state  <= LK_TX;
                            tsh    <= tx_byte;
                            sda_oe <= !tx_byte[BYTE_W-1];
                        end else begin
                            state <= LK_IDLE;
                        end
                    end
                end
                default: state <= LK_IDLE;
            endcase
        end
    end

    // One-cycle status set pulses toward the register file.
    always_comb begin
        ev           = '0;
        ev[SB_ADR]   = (state == LK_ADDR) && byte_done && hit;
        ev[SB_TXM]   = (state == LK_ADDR) && byte_done && hit && sh[0];
        ev[SB_GC]    = (state == LK_ADDR) && byte_done && hit && gc_hit;
        ev[SB_RX]    = (state == LK_RX) && byte_done;
        ev[SB_EMPTY] = quiet_fall && (((state == LK_AACK) && rw_q) ||
                                      ((state == LK_TACK) && host_ack));
        ev[SB_TXD]   = quiet_fall && (state == LK_TACK);
        ev[SB_STOP]  = stop_det && sel;
    end

    // R11
    sda_low_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe && !$past(sda_oe)) |-> $past(scl_fall));

    // R2
    addr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LK_ADDR) |-> !sda_oe);

    // R6
    empty_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev[SB_EMPTY] |-> rw_q);

    // R5
    nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LK_RACK && nak_q) |-> !sda_oe);
endmodule

// File: rtl/i2c_tgt_regs.sv
// Register file: control, write-zero-to-clear status, enables, own address, data port.
// Assumes: one write strobe per cycle, reads without side effects.
module i2c_tgt_regs
    import i2c_tgt_pkg::*;
#(
    parameter int RA_W  = 6,
    parameter int BUS_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [RA_W-1:0]   addr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [ST_W-1:0]   ev,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic [BUS_W-1:0]  rdata,
    output logic [CT_W-1:0]   ctrl,
    output logic [ADR_W-1:0]  own,
    output logic [BYTE_W-1:0] txb,
    output logic              irq
);
    logic [ST_W-1:0] st, ien, keep;
    logic            wr_st;
    logic            unused_hi;

    assign unused_hi = ^wdata[BUS_W-1:BYTE_W];

    // Keep mask: a status write keeps only the bits written as one.
    always_comb begin
        wr_st = wr && (addr == RA_W'(OFS_STAT));
        keep  = wr_st ? wdata[ST_W-1:0] : '1;
    end

    // Plain read/write registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
            ien  <= '0;
            own  <= '0;
            txb  <= '0;
        end else if (wr) begin
            case (addr)
                RA_W'(OFS_CTRL): ctrl <= wdata[CT_W-1:0];
                RA_W'(OFS_IEN):  ien  <= wdata[ST_W-1:0];
                RA_W'(OFS_OWN):  own  <= wdata[ADR_W-1:0];
                RA_W'(OFS_DATA): txb  <= wdata[BYTE_W-1:0];
                default: ;
            endcase
        end
    end

    // Status: bus events set, software clears; a same-cycle event wins.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= '0;
        else        st <= (st & keep) | ev;
    end

    // Read mux, zero-extended.
    always_comb begin
        rdata = '0;
        case (addr)
            RA_W'(OFS_CTRL): rdata[CT_W-1:0]   = ctrl;
            RA_W'(OFS_STAT): rdata[ST_W-1:0]   = st;
            RA_W'(OFS_IEN):  rdata[ST_W-1:0]   = ien;
            RA_W'(OFS_OWN):  rdata[ADR_W-1:0]  = own;
            RA_W'(OFS_DATA): rdata[BYTE_W-1:0] = rx_byte;
            default: ;
        endcase
    end

    // Interrupt from enabled status bits.
    assign irq = |(st & ien);

    // R8
    clr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_st |=> ((st & ~$past(wdata[ST_W-1:0]) & ~$past(ev)) == '0));

    // R8
    no_soft_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st & ~$past(st) & ~$past(ev)) == '0));

    // R9
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == '0) |-> !irq);
endmodule

// File: rtl/i2c_tgt_ctrl.sv
// Top of the I2C target controller: synchronizer, bit engine, register file.
// Assumes: SDA pad drives zero when sda_oe is high; SCL is never stretched.
module i2c_tgt_ctrl
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int RA_W        = 6,
    parameter int BUS_W       = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [RA_W-1:0]  reg_addr,
    input  logic [BUS_W-1:0] reg_wdata,
    output logic [BUS_W-1:0] reg_rdata,
    output logic             irq,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe
);
    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [CT_W-1:0]   ctrl;
    logic [ADR_W-1:0]  own;
    logic [BYTE_W-1:0] txb, rx_byte;
    logic [ST_W-1:0]   ev;

    i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_tgt_link u_link (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .en(ctrl[CB_EN]), .gc_en(ctrl[CB_GCEN]), .force_nack(ctrl[CB_FNACK]),
        .own_addr(own), .tx_byte(txb),
        .sda_oe(sda_oe), .rx_byte(rx_byte), .ev(ev)
    );

    i2c_tgt_regs #(.RA_W(RA_W), .BUS_W(BUS_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .ev(ev), .rx_byte(rx_byte),
        .rdata(reg_rdata), .ctrl(ctrl), .own(own), .txb(txb), .irq(irq)
    );
endmodule

// File: tb/i2c_tgt_ctrl_bench.sv
// Bench: behavioural I2C host plus register-level checks of the target.
module i2c_tgt_ctrl_bench;
    localparam int Q  = 6;
    localparam int WD = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, sda_oe;
    logic        h_scl = 1'b1, h_sda = 1'b1;
    logic        sda_line;
    int          n_cmp = 0, n_bad = 0, cyc = 0, viol = 0;
    logic        oe_prev = 1'b0;

    always #4 clk = ~clk;

    assign sda_line = h_sda & ~sda_oe;

    i2c_tgt_ctrl u_i2c_tgt_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .scl_i(h_scl), .sda_i(sda_line), .sda_oe(sda_oe)
    );

    // R11 monitor: the target must not start pulling SDA while SCL is high.
    always @(posedge clk) begin
        if (rst_n && sda_oe && !oe_prev && h_scl) viol++;
        oe_prev <= sda_oe;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == WD) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog act=%0d exp<%0d", cyc, WD);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic h_start();
        h_sda = 1'b1; h_scl = 1'b1; wq();
        h_sda = 1'b0; wq();
        h_scl = 1'b0; wq();
    endtask

    task automatic h_stop();
        h_sda = 1'b0; wq();
        h_scl = 1'b1; wq();
        h_sda = 1'b1; wq();
    endtask

    task automatic send_bit(logic b);
        h_sda = b; wq();
        h_scl = 1'b1; wq(); wq();
        h_scl = 1'b0; wq();
    endtask

    task automatic recv_bit(output logic b);
        h_sda = 1'b1; wq();
        h_scl = 1'b1; wq();
        b = sda_line; wq();
        h_scl = 1'b0; wq();
    endtask

    task automatic write_byte(logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(b);
        ack = !b;
    endtask

    task automatic read_byte(logic ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
        send_bit(!ack);
    endtask

    initial begin
        logic [31:0] d;
        logic        ack;
        logic [7:0]  by;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(6'h00, d); chk("R1 ctrl", d, 0);
        rd(6'h08, d); chk("R1 status", d, 0);
        rd(6'h10, d); chk("R1 ien", d, 0);
        rd(6'h1C, d); chk("R1 own", d, 0);
        chk("R1 irq", {31'd0, irq}, 0);
        chk("R1 sda_oe", {31'd0, sda_oe}, 0);

        // R10 map, widths and zero extension
        wr(6'h00, 32'hFFFF_FFFF); rd(6'h00, d); chk("R10 ctrl width", d, 32'h0F);
        wr(6'h1C, 32'h5A);        rd(6'h1C, d); chk("R10 own", d, 32'h5A);
        wr(6'h10, 32'hFFFF_FF81); rd(6'h10, d); chk("R10 ien width", d, 32'h01);
        rd(6'h04, d);             chk("R10 unmapped", d, 0);
        wr(6'h00, 32'h0C);

        // R2 foreign address ignored; R7 no STOP flag for it
        h_start(); write_byte(8'h66, ack); h_stop();
        chk("R2 foreign nack", {31'd0, ack}, 0);
        rd(6'h08, d); chk("R7 foreign no flags", d, 0);

        // R2 / R4 host write
        h_start(); write_byte(8'hB4, ack);
        chk("R2 own ack", {31'd0, ack}, 1);
        rd(6'h08, d); chk("R2 match flag", d, 32'h01);
        chk("R9 irq on", {31'd0, irq}, 1);
        rd(6'h24, d); chk("R4 dummy", d, 32'hB4);
        wr(6'h08, 32'hFE); rd(6'h08, d); chk("R8 clear bit0", d, 0);
        chk("R9 irq off", {31'd0, irq}, 0);
        wr(6'h08, 32'hFF); rd(6'h08, d); chk("R8 ones no set", d, 0);
        write_byte(8'hC3, ack);
        chk("R4 data ack", {31'd0, ack}, 1);
        rd(6'h08, d); chk("R4 rx flag", d, 32'h02);
        rd(6'h24, d); chk("R4 rx byte", d, 32'hC3);
        chk("R9 masked", {31'd0, irq}, 0);
        wr(6'h08, 32'hFD);

        // R5 forced NACK
        wr(6'h00, 32'h0D);
        write_byte(8'h7E, ack);
        chk("R5 nack", {31'd0, ack}, 0);
        rd(6'h24, d); chk("R5 byte kept", d, 32'h7E);
        wr(6'h00, 32'h0C);
        h_stop();
        rd(6'h08, d); chk("R7 stop flag", d, 32'h12);
        wr(6'h08, 32'h00);

        // R6 host read, one byte ahead
        wr(6'h24, 32'hA5);
        h_start(); write_byte(8'hB5, ack);
        chk("R6 read addr ack", {31'd0, ack}, 1);
        rd(6'h08, d); chk("R6 match flags", d, 32'h29);
        wr(6'h08, 32'h00);
        wr(6'h24, 32'h3C);
        read_byte(1'b1, by); chk("R6 byte0", {24'd0, by}, 32'hA5);
        rd(6'h08, d); chk("R6 sent+empty", d, 32'h0C);
        wr(6'h08, 32'h00);
        read_byte(1'b0, by); chk("R6 byte1", {24'd0, by}, 32'h3C);
        rd(6'h08, d); chk("R6 nack no reload", d, 32'h04);
        chk("R6 released", {31'd0, sda_oe}, 0);
        h_stop();
        rd(6'h08, d); chk("R7 stop after read", d, 32'h14);
        wr(6'h08, 32'h00);

        // R3 general call
        h_start(); write_byte(8'h00, ack); h_stop();
        chk("R3 gc off nack", {31'd0, ack}, 0);
        wr(6'h00, 32'h0E);
        h_start(); write_byte(8'h00, ack);
        chk("R3 gc ack", {31'd0, ack}, 1);
        rd(6'h08, d); chk("R3 gc flags", d, 32'h41);
        h_stop();
        wr(6'h08, 32'h00);

        // R2 disabled interface
        wr(6'h00, 32'h08);
        h_start(); write_byte(8'hB4, ack); h_stop();
        chk("R2 disabled nack", {31'd0, ack}, 0);
        rd(6'h08, d); chk("R2 disabled flags", d, 0);

        // R11
        chk("R11 sda edges", viol, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule